// File: doc/BRIEF.md
# Timer Channel Counting-Clock Selector and Gate

This block decides, once per master clock cycle, whether the counter of one timer channel advances. It picks one source from five internal prescaled clock levels and three external clock levels. It can invert that source and can qualify it with a burst gating level. It then turns each rising edge of the resulting level into a pulse on `cnt_en` that is exactly one master clock wide. External levels are brought into the master domain through a synchroniser. Internal levels pass through a pipeline of the same depth, so every source has the same latency.

Two layers of gating sit on top of the edge detector. The first layer is the enabled/disabled layer. Only the enable and disable commands change it, plus an optional automatic disable tied to the channel mode. The second layer is the started/stopped layer. Triggers start the clock, and an optional mode-dependent event stops it. This layer is frozen while the clock is disabled. A small state machine holds both layers in three states:

- `CLK_OFF`: disabled, and therefore also stopped.
- `CLK_HALT`: enabled but stopped.
- `CLK_RUN`: enabled and started.

The state machine has these transitions:

- OFF→HALT on an enable command.
- HALT→RUN on any trigger.
- RUN→HALT on a stop event with no trigger in the same cycle.
- Any state→OFF on a disable command or an automatic disable event.

Top module: `tmr_clk_ctrl`

## Requirements
- R1: `cfg_clk_sel` value k in 0..4 selects `int_clk[k]`, and values 5, 6 and 7 select `ext_clk[0]`, `ext_clk[1]` and `ext_clk[2]`. While running, `cnt_en` pulses once per rising edge of the selected level.
- R2: With `cfg_invert`=1, pulses come from falling edges of the selected level, and rising edges produce none.
- R3: `cfg_burst` value 0 means no gating, and values 1, 2 and 3 gate with `ext_clk[0]`, `ext_clk[1]` and `ext_clk[2]`. The selected clock is passed only while the gating level is high.
- R4: Suppose a source level changes between two master clock edges. The resulting `cnt_en` pulse becomes visible after the third rising master edge that follows the change. The pulse lasts exactly one cycle.
- R5: `cmd_enable` sets `stat_enabled` after the next edge, and `cmd_disable` clears it. When both arrive in the same cycle, disable wins.
- R6: While the clock is disabled, triggers and stop events are ignored, and triggers do not set `stat_enabled`. An enable command leaves the clock stopped.
- R7: Each of `trig_sw`, `trig_sync`, `trig_ext` and `trig_cmp` starts an enabled clock.
- R8: In capture mode (`cfg_wave_mode`=0), `evt_load_b` stops the clock if `cfg_auto_stop` is set. It disables the clock if `cfg_auto_disable` is set. `evt_cmp_c` has no effect in this mode.
- R9: In waveform mode (`cfg_wave_mode`=1), `evt_cmp_c` stops the clock if `cfg_auto_stop` is set. It disables the clock if `cfg_auto_disable` is set. `evt_load_b` has no effect in this mode.
- R10: A trigger and a stop event in the same cycle leave the clock started. A disable (commanded or automatic) overrides a trigger in the same cycle.
- R11: `cnt_en` is high only when the clock was enabled and started at the sampling edge.
- R12: After reset the clock is disabled and stopped, and `cnt_en` and `stat_enabled` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | active-low asynchronous reset |
| int_clk | input | 5 | internal prescaled clock levels, synchronous to clk |
| ext_clk | input | 3 | external clock / gating levels, asynchronous |
| cfg_clk_sel | input | 3 | source select (R1 encoding) |
| cfg_invert | input | 1 | count on falling edges |
| cfg_burst | input | 2 | gating source select (R3 encoding) |
| cfg_wave_mode | input | 1 | 0 capture mode, 1 waveform mode |
| cfg_auto_disable | input | 1 | mode event disables the clock |
| cfg_auto_stop | input | 1 | mode event stops the clock |
| cmd_enable | input | 1 | enable command pulse |
| cmd_disable | input | 1 | disable command pulse |
| trig_sw | input | 1 | software trigger |
| trig_sync | input | 1 | synchronisation trigger |
| trig_ext | input | 1 | external trigger |
| trig_cmp | input | 1 | compare trigger |
| evt_load_b | input | 1 | B-register load event |
| evt_cmp_c | input | 1 | C-register compare event |
| cnt_en | output | 1 | one-cycle count-enable pulse |
| stat_enabled | output | 1 | clock enabled status |

## Verification
A state machine stuck in or wrongly entering `CLK_OFF` shows on `stat_enabled` one edge after the offending command or event. A confusion between `CLK_HALT` and `CLK_RUN` only shows as missing or extra `cnt_en` pulses. For that reason the bench measures pulse counts over windows that span whole source periods, starting a few cycles after each event. A wrong synchroniser depth or edge register shows as a pulse arriving one cycle early or late. It can also show as a pulse lasting two cycles. The bench therefore samples the cycle-exact position of single pulses after a controlled level change.

// File: rtl/tmr_clk_pkg.sv
package tmr_clk_pkg;

    // Gating state of the counting clock
    typedef enum logic [1:0] {
        CLK_OFF  = 2'd0,   // disabled (implies stopped)
        CLK_HALT = 2'd1,   // enabled, stopped
        CLK_RUN  = 2'd2    // enabled, started
    } clk_state_e;

    // Trigger sources that start the clock
    localparam int N_TRIG = 4;

endpackage

// File: rtl/tcc_stage_pipe.sv
// Multi-stage resettable register chain: a synchroniser for asynchronous
// inputs, a latency-matching delay for synchronous ones.
module tcc_stage_pipe #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tcc_edge_src.sv
// Source multiplexer, polarity control, burst gating and rising-edge detect.
module tcc_edge_src #(
    parameter int N_INT   = 5,
    parameter int N_EXT   = 3,
    parameter int SEL_W   = $clog2(N_INT + N_EXT),
    parameter int BURST_W = $clog2(N_EXT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_INT-1:0]   int_lvl,
    input  logic [N_EXT-1:0]   ext_lvl,
    input  logic [SEL_W-1:0]   sel,
    input  logic               invert,
    input  logic [BURST_W-1:0] burst,
    output logic               edge_hit
);
    localparam int N_SRC = N_INT + N_EXT;

    logic [N_SRC-1:0] all_lvl;
    logic             picked;
    logic             gate;
    logic             qualified;
    logic             qualified_q;

    assign all_lvl = {ext_lvl, int_lvl};

    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (sel == SEL_W'(i)) begin
                picked = all_lvl[i];
            end
        end
    end

    always_comb begin
        gate = 1'b1;
        for (int j = 0; j < N_EXT; j++) begin
            if (burst == BURST_W'(j + 1)) begin
                gate = ext_lvl[j];
            end
        end
    end

    assign qualified = (picked ^ invert) & gate;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qualified_q <= 1'b0;
        end else begin
            qualified_q <= qualified;
        end
    end

    assign edge_hit = qualified & ~qualified_q;
endmodule

// File: rtl/tcc_gate_fsm.sv
// Enabled/started state machine and registered count-enable output.
module tcc_gate_fsm
    import tmr_clk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_enable,
    input  logic              cmd_disable,
    input  logic [N_TRIG-1:0] trig,
    input  logic              wave_mode,
    input  logic              auto_disable,
    input  logic              auto_stop,
    input  logic              evt_load_b,
    input  logic              evt_cmp_c,
    input  logic              edge_hit,
    output logic              cnt_en,
    output logic              enabled
);
    clk_state_e state_q;
    clk_state_e state_d;
    logic       mode_evt;
    logic       start_evt;
    logic       stop_evt;
    logic       kill_evt;

    always_comb begin
        mode_evt  = wave_mode ? evt_cmp_c : evt_load_b;
        start_evt = |trig;
        stop_evt  = auto_stop & mode_evt;
        kill_evt  = cmd_disable | (auto_disable & mode_evt);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CLK_OFF: begin
                if (cmd_enable) begin
                    state_d = CLK_HALT;
                end
            end
            CLK_HALT: begin
                if (start_evt) begin
                    state_d = CLK_RUN;
                end
            end
            CLK_RUN: begin
                if (stop_evt && !start_evt) begin
                    state_d = CLK_HALT;
                end
            end
            default: begin
                state_d = CLK_OFF;
            end
        endcase
        if (kill_evt) begin
            state_d = CLK_OFF;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CLK_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_en <= 1'b0;
        end else begin
            cnt_en <= edge_hit && (state_q == CLK_RUN);
        end
    end

    assign enabled = (state_q != CLK_OFF);
endmodule

// File: rtl/tmr_clk_ctrl.sv
// Counting-clock selection and control for one timer channel.
module tmr_clk_ctrl
    import tmr_clk_pkg::*;
#(
    parameter int N_INT       = 5,
    parameter int N_EXT       = 3,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = $clog2(N_INT + N_EXT),
    localparam int BURST_W    = $clog2(N_EXT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_INT-1:0]   int_clk,
    input  logic [N_EXT-1:0]   ext_clk,
    input  logic [SEL_W-1:0]   cfg_clk_sel,
    input  logic               cfg_invert,
    input  logic [BURST_W-1:0] cfg_burst,
    input  logic               cfg_wave_mode,
    input  logic               cfg_auto_disable,
    input  logic               cfg_auto_stop,
    input  logic               cmd_enable,
    input  logic               cmd_disable,
    input  logic               trig_sw,
    input  logic               trig_sync,
    input  logic               trig_ext,
    input  logic               trig_cmp,
    input  logic               evt_load_b,
    input  logic               evt_cmp_c,
    output logic               cnt_en,
    output logic               stat_enabled
);
    logic [N_INT-1:0] int_lvl;
    logic [N_EXT-1:0] ext_lvl;
    logic             edge_hit;
    logic [N_TRIG-1:0] trig_bus;

    // Asynchronous external levels: synchroniser
    for (genvar e = 0; e < N_EXT; e++) begin : g_ext_sync
        tcc_stage_pipe #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (ext_clk[e]),
            .q     (ext_lvl[e])
        );
    end

    // Synchronous internal levels: equal-latency delay
    for (genvar n = 0; n < N_INT; n++) begin : g_int_dly
        tcc_stage_pipe #(.STAGES(SYNC_STAGES)) u_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (int_clk[n]),
            .q     (int_lvl[n])
        );
    end

    tcc_edge_src #(
        .N_INT   (N_INT),
        .N_EXT   (N_EXT),
        .SEL_W   (SEL_W),
        .BURST_W (BURST_W)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .int_lvl  (int_lvl),
        .ext_lvl  (ext_lvl),
        .sel      (cfg_clk_sel),
        .invert   (cfg_invert),
        .burst    (cfg_burst),
        .edge_hit (edge_hit)
    );

    assign trig_bus = {trig_cmp, trig_ext, trig_sync, trig_sw};

    tcc_gate_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_enable   (cmd_enable),
        .cmd_disable  (cmd_disable),
        .trig         (trig_bus),
        .wave_mode    (cfg_wave_mode),
        .auto_disable (cfg_auto_disable),
        .auto_stop    (cfg_auto_stop),
        .evt_load_b   (evt_load_b),
        .evt_cmp_c    (evt_cmp_c),
        .edge_hit     (edge_hit),
        .cnt_en       (cnt_en),
        .enabled      (stat_enabled)
    );
endmodule

// File: rtl/tmr_clk_ctrl_chk.sv
// Property checker for tmr_clk_ctrl, attached by bind.
module tmr_clk_ctrl_chk #(
    parameter int N_INT   = 5,
    parameter int N_EXT   = 3,
    parameter int SEL_W   = $clog2(N_INT + N_EXT),
    parameter int BURST_W = $clog2(N_EXT + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_INT-1:0]   int_clk,
    input logic [N_EXT-1:0]   ext_clk,
    input logic [SEL_W-1:0]   cfg_clk_sel,
    input logic               cfg_invert,
    input logic [BURST_W-1:0] cfg_burst,
    input logic               cfg_wave_mode,
    input logic               cfg_auto_disable,
    input logic               cfg_auto_stop,
    input logic               cmd_enable,
    input logic               cmd_disable,
    input logic               trig_sw,
    input logic               trig_sync,
    input logic               trig_ext,
    input logic               trig_cmp,
    input logic               evt_load_b,
    input logic               evt_cmp_c,
    input logic               cnt_en,
    input logic               stat_enabled
);
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en |=> !cnt_en);

    assert_disable_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_disable |=> !stat_enabled);

    assert_trig_no_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_enabled && !cmd_enable) |=> !stat_enabled);

    assert_off_no_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_enabled |=> !cnt_en);

    assert_cap_autodis_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wave_mode && cfg_auto_disable && evt_load_b) |=> !stat_enabled);

    assert_wave_autodis_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wave_mode && cfg_auto_disable && evt_cmp_c) |=> !stat_enabled);

    assert_enable_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_enable && !cmd_disable && !cfg_auto_disable) |=> stat_enabled);
endmodule

bind tmr_clk_ctrl tmr_clk_ctrl_chk u_chk (.*);

// File: tb/tmr_clk_ctrl_tb.sv
module tmr_clk_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] int_clk;
    logic [2:0] ext_clk;
    logic [2:0] cfg_clk_sel = '0;
    logic       cfg_invert = 1'b0;
    logic [1:0] cfg_burst = '0;
    logic       cfg_wave_mode = 1'b0;
    logic       cfg_auto_disable = 1'b0;
    logic       cfg_auto_stop = 1'b0;
    logic [7:0] ev = '0;  // 0 en,1 dis,2 sw,3 sync,4 ext,5 cmp trig,6 load_b,7 cmp_c
    logic       cnt_en;
    logic       stat_enabled;

    localparam logic [7:0] EV_EN = 8'h01, EV_DIS = 8'h02, EV_SW = 8'h04,
                           EV_SYNC = 8'h08, EV_EXT = 8'h10, EV_TCMP = 8'h20,
                           EV_LDB = 8'h40, EV_CMPC = 8'h80;

    int nchk = 0;
    int nfail = 0;
    logic [31:0] cyc = '0;
    logic        ext_free = 1'b0;
    logic [2:0]  ext_man = '0;
    logic [2:0]  ext_gen;
    logic        prev_cnt = 1'b0;
    int          width_err = 0;

    always #5 clk = ~clk;

    always @(negedge clk) cyc <= cyc + 1;
    assign int_clk = cyc[5:1];
    assign ext_gen[0] = (cyc % 6)  < 3;
    assign ext_gen[1] = (cyc % 10) < 5;
    assign ext_gen[2] = (cyc % 14) < 7;
    assign ext_clk = ext_free ? ext_gen : ext_man;

    always @(negedge clk) begin
        if (rst_n && cnt_en && prev_cnt) width_err++;
        prev_cnt <= cnt_en;
    end

    tmr_clk_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .int_clk(int_clk), .ext_clk(ext_clk),
        .cfg_clk_sel(cfg_clk_sel), .cfg_invert(cfg_invert), .cfg_burst(cfg_burst),
        .cfg_wave_mode(cfg_wave_mode), .cfg_auto_disable(cfg_auto_disable),
        .cfg_auto_stop(cfg_auto_stop), .cmd_enable(ev[0]), .cmd_disable(ev[1]),
        .trig_sw(ev[2]), .trig_sync(ev[3]), .trig_ext(ev[4]), .trig_cmp(ev[5]),
        .evt_load_b(ev[6]), .evt_cmp_c(ev[7]), .cnt_en(cnt_en),
        .stat_enabled(stat_enabled)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fire(input logic [7:0] m);
        ev = m;
        @(negedge clk);
        ev = '0;
    endtask

    task automatic count(input int n, output int c);
        c = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (cnt_en) c++;
        end
    endtask

    task automatic t_reset();
        int c;
        chk("R12 cnt_en after reset", cnt_en, 0);
        chk("R12 stat_enabled after reset", stat_enabled, 0);
        count(64, c);
        chk("R12 no pulses before enable", c, 0);
    endtask

    task automatic t_enable_start();
        int c;
        fire(EV_EN);
        chk("R5 enable sets status", stat_enabled, 1);
        count(64, c);
        chk("R6 enable leaves clock stopped", c, 0);
        fire(EV_SW);
        wait_n(8);
        count(256, c);
        chk("R7 software trigger starts", c, 64);
    endtask

    task automatic t_internal();
        int c;
        for (int i = 0; i < 5; i++) begin
            cfg_clk_sel = 3'(i);
            wait_n(8);
            count(256, c);
            chk($sformatf("R1 internal select %0d", i), c, 64 >> i);
        end
    endtask

    task automatic t_external();
        int c;
        int exp_c [3] = '{70, 42, 30};
        ext_free = 1'b1;
        for (int j = 0; j < 3; j++) begin
            cfg_clk_sel = 3'(5 + j);
            wait_n(16);
            count(420, c);
            chk($sformatf("R1 external select %0d", j), c, exp_c[j]);
        end
        ext_free = 1'b0;
    endtask

    task automatic t_latency();
        int got;
        ext_man = '0;
        cfg_clk_sel = 3'd7;
        cfg_invert = 1'b0;
        wait_n(8);
        ext_man[2] = 1'b1;
        got = 0;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            if (cnt_en) got = got | (1 << k);
        end
        chk("R4 pulse after third edge only", got, 8);
        ext_man[2] = 1'b0;
        got = 0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (cnt_en) got++;
        end
        chk("R1 no pulse on falling edge", got, 0);
        cfg_invert = 1'b1;
        wait_n(8);
        ext_man[2] = 1'b1;
        got = 0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (cnt_en) got++;
        end
        chk("R2 inverted: rising edge ignored", got, 0);
        ext_man[2] = 1'b0;
        got = 0;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            if (cnt_en) got = got | (1 << k);
        end
        chk("R2 inverted: falling edge counts", got, 8);
        cfg_invert = 1'b0;
        wait_n(8);
    endtask

    task automatic t_burst();
        int c;
        ext_man = '0;
        cfg_clk_sel = 3'd0;
        cfg_burst = 2'd1;
        wait_n(8);
        count(64, c);
        chk("R3 gate X0 low blocks", c, 0);
        ext_man[0] = 1'b1;
        wait_n(8);
        count(64, c);
        chk("R3 gate X0 high passes", c, 16);
        cfg_burst = 2'd2;
        wait_n(8);
        count(64, c);
        chk("R3 gate X1 low blocks", c, 0);
        cfg_burst = 2'd0;
        wait_n(8);
        count(64, c);
        chk("R3 no gating passes", c, 16);
        ext_man = '0;
    endtask

    task automatic t_disable();
        int c;
        fire(EV_DIS);
        chk("R5 disable clears status", stat_enabled, 0);
        count(64, c);
        chk("R11 no count while disabled", c, 0);
        fire(EV_SW);
        fire(EV_SYNC | EV_EXT | EV_TCMP);
        chk("R6 triggers do not enable", stat_enabled, 0);
        fire(EV_EN);
        chk("R5 re-enable", stat_enabled, 1);
        wait_n(8);
        count(64, c);
        chk("R6 triggers while disabled ignored", c, 0);
        fire(EV_EN | EV_DIS);
        chk("R5 enable+disable: disable wins", stat_enabled, 0);
        fire(EV_EN);
    endtask

    task automatic t_triggers();
        int c;
        logic [7:0] tl [3] = '{EV_SYNC, EV_EXT, EV_TCMP};
        cfg_wave_mode = 1'b0;
        cfg_auto_stop = 1'b1;
        cfg_auto_disable = 1'b0;
        for (int t = 0; t < 3; t++) begin
            fire(EV_LDB);
            wait_n(8);
            count(64, c);
            chk($sformatf("R8 stopped before trigger %0d", t), c, 0);
            fire(tl[t]);
            wait_n(8);
            count(64, c);
            chk($sformatf("R7 trigger %0d starts", t), c, 16);
        end
    endtask

    task automatic t_capture();
        int c;
        cfg_wave_mode = 1'b0;
        cfg_auto_stop = 1'b0;
        cfg_auto_disable = 1'b0;
        fire(EV_LDB);
        wait_n(8);
        count(64, c);
        chk("R8 load_b without options no effect", c, 16);
        cfg_auto_stop = 1'b1;
        cfg_auto_disable = 1'b1;
        fire(EV_CMPC);
        wait_n(8);
        count(64, c);
        chk("R8 cmp_c ignored in capture mode", c, 16);
        chk("R8 cmp_c leaves enabled", stat_enabled, 1);
        cfg_auto_disable = 1'b0;
        fire(EV_LDB);
        wait_n(8);
        count(64, c);
        chk("R8 load_b stops", c, 0);
        chk("R8 stop keeps enabled", stat_enabled, 1);
        cfg_auto_disable = 1'b1;
        fire(EV_SW);
        fire(EV_LDB);
        chk("R8 load_b disables", stat_enabled, 0);
        cfg_auto_disable = 1'b0;
        cfg_auto_stop = 1'b0;
    endtask

    task automatic t_wave();
        int c;
        fire(EV_EN);
        cfg_wave_mode = 1'b1;
        cfg_auto_stop = 1'b1;
        cfg_auto_disable = 1'b0;
        fire(EV_SW);
        fire(EV_LDB);
        wait_n(8);
        count(64, c);
        chk("R9 load_b ignored in waveform mode", c, 16);
        fire(EV_CMPC);
        wait_n(8);
        count(64, c);
        chk("R9 cmp_c stops", c, 0);
        chk("R9 stop keeps enabled", stat_enabled, 1);
        fire(EV_SW);
        cfg_auto_disable = 1'b1;
        fire(EV_CMPC);
        chk("R9 cmp_c disables", stat_enabled, 0);
        cfg_auto_disable = 1'b0;
    endtask

    task automatic t_conflict();
        int c;
        fire(EV_EN);
        cfg_wave_mode = 1'b1;
        cfg_auto_stop = 1'b1;
        fire(EV_SW | EV_CMPC);
        wait_n(8);
        count(64, c);
        chk("R10 start+stop from stopped: start wins", c, 16);
        fire(EV_SW | EV_CMPC);
        wait_n(8);
        count(64, c);
        chk("R10 start+stop while running: stays started", c, 16);
        cfg_auto_disable = 1'b1;
        fire(EV_SW | EV_CMPC);
        chk("R10 disable beats trigger", stat_enabled, 0);
        cfg_auto_disable = 1'b0;
        fire(EV_EN);
        wait_n(8);
        count(64, c);
        chk("R11 enabled but stopped: no count", c, 0);
    endtask

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);
        t_reset();
        t_enable_start();
        t_internal();
        cfg_clk_sel = 3'd0;
        t_external();
        t_latency();
        t_burst();
        cfg_clk_sel = 3'd0;
        wait_n(8);
        t_disable();
        fire(EV_SW);
        t_triggers();
        t_capture();
        t_wave();
        t_conflict();
        chk("R4 pulse width one cycle", width_err, 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule